// File: doc/BRIEF.md
# Byte-Write Pipelined Memory Data Path

This block is the data side of a 32-bit synchronous pipelined memory with a shared data bus. Each clock edge it decides whether the selected array word is read, written or left alone. It turns the global write, byte-write enable and per-byte selects into four byte write strobes. It registers read data into an output stage, and it computes the enable that would drive the shared bus. The bus is split into `din`, `dout` and `dq_oe` so that simulation can observe it.

A cycle is opened by one of two active-low address strobes while the chip select is high. The processor strobe always opens a read. Write controls shown on that edge are ignored, so a write opened this way lands on the following edge. The controller strobe writes on its own edge when write controls are active. With no strobe on an edge, an open cycle continues. The continuation writes when write controls are active and reads otherwise, in both cases at the word address supplied by the external address generator. This is how bursts proceed.

The bus enable combines four conditions. A read result must be waiting. The output enable is asynchronous and must be low. The first read after leaving the deselected state is masked. Any write cycle currently presented on the inputs blanks the bus.

Top module: `sram_byte_datapath`

## Requirements
- R1: When `gwr_n` is low on a write edge, all four bytes of the addressed word take `din`, whatever `bwen_n` and `bsel_n` are.
- R2: When `gwr_n` is high, byte lane i (bits [8i+7:8i]) is written only if `bwen_n` is low and `bsel_n[i]` is low. The other lanes keep their old contents.
- R3: An edge where no byte strobe results (`gwr_n` high and either `bwen_n` high or all `bsel_n` high) is a read, and memory is unchanged.
- R4: An edge with `sel` high and `pstb_n` low is always a read, whatever the write controls are. Write controls on the next edge with no strobe then write that edge's `din`, so such a write takes two edges.
- R5: An edge with `sel` high, `pstb_n` high, `cstb_n` low and write controls active writes `din` on that same edge.
- R6: A read edge loads the addressed word into `dout`, and `dout` shows it for the cycle after that edge.
- R7: After reset or a deselect, the cycle that follows the first strobe edge has `dq_oe` low regardless of `oe_n`. From the next read on, `oe_n` decides.
- R8: While the inputs present a write cycle (a controller-strobe write, or write controls on a continuation), `dq_oe` is low, independent of `oe_n`.
- R9: An edge with `sel` low and either strobe low deselects. `dq_oe` is low from the following cycle until a new strobe opens a cycle.
- R10: `oe_n` high forces `dq_oe` low with no clock edge needed, and returning it low restores the drive in the same cycle.
- R11: On an edge with both strobes high inside an open cycle, the word at `addr` is written when write controls are active and read otherwise. Consecutive edges therefore form burst writes or pipelined reads.
- R12: After reset the block is deselected and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Combined chip select, high = selected, sampled with a strobe |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| gwr_n | input | 1 | Global write, active low, all bytes |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-byte selects, active low, bit i = lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 6 | Word address from the address generator |
| din | input | 32 | Write data, sampled at the write edge |
| dout | output | 32 | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The overlap that matters is a pending read result meeting a write in the next cycle. This happens either as the second edge of a processor-strobe write or as a controller write right after a read. The bench provokes it by presenting write controls in the cycle where `dout` holds a fresh read word. It judges the result by `dq_oe` being low in that cycle while `dout` still holds the old word, and by a later readback returning the newly written bytes.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic active;
        logic rd_valid;
        logic fresh;
    } path_state_t;
endpackage

// File: rtl/sbd_wr_decode.sv
module sbd_wr_decode #(
    parameter int NB = 4
) (
    input  logic          gwr_n,
    input  logic          bwen_n,
    input  logic [NB-1:0] bsel_n,
    output logic [NB-1:0] strb,
    output logic          wr_req
);
    for (genvar i = 0; i < NB; i++) begin : g_strb
        assign strb[i] = ~gwr_n | (~bwen_n & ~bsel_n[i]);
    end
    assign wr_req = |strb;
endmodule

// File: rtl/sbd_cycle_ctl.sv
module sbd_cycle_ctl
    import sbd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic        pstb_n,
    input  logic        cstb_n,
    input  logic        wr_req,
    output cyc_kind_e   kind,
    output path_state_t st_q
);
    logic        start_any;
    logic        desel;
    logic        cont;
    path_state_t st_d;

    always_comb begin
        start_any = sel & (~pstb_n | ~cstb_n);
        desel     = ~sel & (~pstb_n | ~cstb_n);
        cont      = st_q.active & pstb_n & cstb_n;
        kind      = CYC_NONE;
        if (sel & ~pstb_n)
            kind = CYC_READ;
        else if (start_any | cont)
            kind = wr_req ? CYC_WRITE : CYC_READ;
        st_d.active   = desel ? 1'b0 : (start_any | st_q.active);
        st_d.rd_valid = (kind == CYC_READ);
        st_d.fresh    = start_any & ~st_q.active;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/sbd_byte_ram.sv
module sbd_byte_ram
    import sbd_pkg::*;
#(
    parameter int NB    = 4,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic [NB-1:0]      we,
    input  logic               re,
    input  logic [AW-1:0]      addr,
    input  logic [NB*LANE_W-1:0] wdata,
    output logic [NB*LANE_W-1:0] rdata
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
            if (re)    q <= mem[addr];
        end
        assign rdata[i*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/sram_byte_datapath.sv
module sram_byte_datapath
    import sbd_pkg::*;
#(
    parameter int NB    = 4,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          pstb_n,
    input  logic          cstb_n,
    input  logic          gwr_n,
    input  logic          bwen_n,
    input  logic [NB-1:0] bsel_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dq_oe
);
    logic [NB-1:0] wstrb;
    logic          wr_req;
    cyc_kind_e     kind;
    path_state_t   st_q;
    logic          wr_det;
    logic          path_active;

    sbd_wr_decode #(.NB(NB)) u_dec (
        .gwr_n  (gwr_n),
        .bwen_n (bwen_n),
        .bsel_n (bsel_n),
        .strb   (wstrb),
        .wr_req (wr_req)
    );

    sbd_cycle_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .pstb_n (pstb_n),
        .cstb_n (cstb_n),
        .wr_req (wr_req),
        .kind   (kind),
        .st_q   (st_q)
    );

    assign wr_det      = (kind == CYC_WRITE);
    assign path_active = st_q.active;

    sbd_byte_ram #(.NB(NB), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wstrb & {NB{wr_det}}),
        .re    (kind == CYC_READ),
        .addr  (addr),
        .wdata (din),
        .rdata (dout)
    );

    assign dq_oe = st_q.rd_valid & ~st_q.fresh & ~oe_n & ~wr_det;
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          pstb_n,
    input logic          cstb_n,
    input logic          gwr_n,
    input logic          oe_n,
    input logic          dq_oe,
    input logic          active,
    input logic          wr_det,
    input logic [NB-1:0] wstrb
);
    p_fresh_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (sel && (!pstb_n || !cstb_n) && !active) |=> !dq_oe);

    p_desel_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!sel && (!pstb_n || !cstb_n)) |=> !dq_oe);

    p_write_hiz_r8: assert property (@(posedge clk) disable iff (rst)
        (sel && pstb_n && !cstb_n && !gwr_n) |-> !dq_oe);

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    p_global_all_r1: assert property (@(posedge clk) disable iff (rst)
        (!gwr_n && wr_det) |-> (&wstrb));

    p_pstart_read_r4: assert property (@(posedge clk) disable iff (rst)
        (sel && !pstb_n && active) |=> (wr_det || oe_n || dq_oe));
endmodule

bind sram_byte_datapath sbd_checker #(.NB(NB)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .pstb_n (pstb_n),
    .cstb_n (cstb_n),
    .gwr_n  (gwr_n),
    .oe_n   (oe_n),
    .dq_oe  (dq_oe),
    .active (path_active),
    .wr_det (wr_det),
    .wstrb  (wstrb)
);

// File: tb/sram_byte_datapath_tb.sv
module sram_byte_datapath_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        pstb_n = 1'b1;
    logic        cstb_n = 1'b1;
    logic        gwr_n = 1'b1;
    logic        bwen_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        oe_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dq_oe;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    sram_byte_datapath u_dut (
        .clk(clk), .rst(rst), .sel(sel), .pstb_n(pstb_n), .cstb_n(cstb_n),
        .gwr_n(gwr_n), .bwen_n(bwen_n), .bsel_n(bsel_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic p, input logic c, input logic g,
                         input logic be, input logic [3:0] bs, input logic [5:0] a,
                         input logic [31:0] d);
        @(negedge clk);
        sel = s; pstb_n = p; cstb_n = c; gwr_n = g; bwen_n = be; bsel_n = bs;
        addr = a; din = d;
        #1;
    endtask

    task automatic idle(input logic [5:0] a);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, a, 32'h0);
    endtask

    task automatic cwrite_gl(input logic [5:0] a, input logic [31:0] d);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, a, d);
    endtask

    task automatic read_at(input string tag, input logic [5:0] a, input logic [31:0] exp);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, a, 32'h0);
        idle(a);
        chk({tag, " R6 data"}, dout, exp);
        chk({tag, " R6 enable"}, {31'b0, dq_oe}, 32'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R12 oe after reset", {31'b0, dq_oe}, 32'd0);
    endtask

    task automatic t_cwrite();
        cwrite_gl(6'd5, 32'h11223344);
        idle(6'd5);
        chk("R5 no drive after write", {31'b0, dq_oe}, 32'd0);
        read_at("R1 global write", 6'd5, 32'h11223344);
    endtask

    task automatic t_bytes();
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 6'd5, 32'hAABBCCDD);
        idle(6'd5);
        read_at("R2 lanes 0,2", 6'd5, 32'h11BB33DD);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 6'd5, 32'hFFFFFFFF);
        idle(6'd5);
        chk("R3 bwen high no write", dout, 32'h11BB33DD);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 6'd5, 32'h00000000);
        idle(6'd5);
        chk("R3 no select no write", dout, 32'h11BB33DD);
        chk("R3 is a read", {31'b0, dq_oe}, 32'd1);
    endtask

    task automatic t_pwrite();
        cwrite_gl(6'd9, 32'h0BADF00D);
        idle(6'd9);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9, 32'h12345678);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9, 32'hCAFE0001);
        chk("R4 pstart reads old word", dout, 32'h0BADF00D);
        chk("R8 second-edge write blanks bus", {31'b0, dq_oe}, 32'd0);
        idle(6'd9);
        chk("R4 write edge no drive", {31'b0, dq_oe}, 32'd0);
        read_at("R4 two-edge write", 6'd9, 32'hCAFE0001);
    endtask

    task automatic t_fresh();
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0);
        idle(6'd5);
        chk("R9 deselect off", {31'b0, dq_oe}, 32'd0);
        idle(6'd5);
        chk("R9 stays off", {31'b0, dq_oe}, 32'd0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0);
        idle(6'd5);
        chk("R7 first read masked", {31'b0, dq_oe}, 32'd0);
        chk("R7 data captured", dout, 32'h11BB33DD);
        idle(6'd5);
        chk("R7 later read driven", {31'b0, dq_oe}, 32'd1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd9, 32'h0);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd9, 32'h0);
        idle(6'd9);
        chk("R7 pstart from deselect masked", {31'b0, dq_oe}, 32'd0);
        idle(6'd9);
        chk("R7 pstart then driven", {31'b0, dq_oe}, 32'd1);
        chk("R11 continuation read", dout, 32'hCAFE0001);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        #1;
        chk("R10 oe high async off", {31'b0, dq_oe}, 32'd0);
        oe_n = 1'b0;
        #1;
        chk("R10 oe low async on", {31'b0, dq_oe}, 32'd1);
    endtask

    task automatic t_burst();
        cwrite_gl(6'd20, 32'hD0D0D0D0);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 6'd21, 32'hD1D1D1D1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd22, 32'hD2D2D2D2);
        idle(6'd22);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd20, 32'h0);
        idle(6'd21);
        chk("R11 burst word 0", dout, 32'hD0D0D0D0);
        idle(6'd22);
        chk("R11 burst word 1", dout, 32'hD1D1D1D1);
        idle(6'd22);
        chk("R11 burst word 2", dout, 32'hD2D2D2D2);
        chk("R6 pipelined drive", {31'b0, dq_oe}, 32'd1);
    endtask

    task automatic t_collide();
        read_at("R8 pre-read", 6'd5, 32'h11BB33DD);
        cwrite_gl(6'd5, 32'h55555555);
        chk("R8 controller write blanks", {31'b0, dq_oe}, 32'd0);
        chk("R8 old word held", dout, 32'h11BB33DD);
        idle(6'd5);
        read_at("R5 same-edge write", 6'd5, 32'h55555555);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0);
        idle(6'd5);
        chk("R9 deselect from active", {31'b0, dq_oe}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_cwrite();
        t_bytes();
        t_pwrite();
        t_fresh();
        t_oe();
        t_burst();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule